// File: doc/BRIEF.md
# Console Buffer Transfer Engine

This engine executes the two bulk buffer commands of a simple console peripheral. After a one-cycle start pulse it latches a direction, a 64-bit memory address and a 32-bit byte count. In the outbound direction it fetches bytes from memory one at a time over a byte-wide request/response port, stages them in a small internal buffer, and streams each staged chunk out on a valid/ready transmit port. In the inbound direction it takes bytes from the head of a receive FIFO and stores them at successive memory addresses over a request/accept write port.

The outbound direction always moves the whole programmed count, working through it in chunks no larger than the staging buffer. The inbound direction ends as soon as either the count is used up or the receive FIFO has nothing left. Completion is a one-cycle pulse that carries the number of bytes actually moved. In the same cycle, the engine raises a pulse that tells the interrupt logic to drop its line when interrupts are enabled and the receive FIFO is empty at the end of an inbound transfer.

Top module: `con_buf_dma`

## Requirements
- R1: Outbound transfer (dir = 0) sends exactly `length` bytes on the transmit port. Byte i equals the memory content at `start_addr + i`, and the bytes go out in order of increasing i.
- R2: Memory addresses, for both reads and writes, begin at `start_addr` and step by one per byte, wrapping modulo 2^64 with no alignment rule.
- R3: Outbound bytes are staged in chunks of at most CHUNK bytes (default 16). A chunk is read from memory in full before any of it is sent, so fetched-but-unsent bytes never exceed CHUNK, and a long transfer reaches that bound.
- R4: Inbound transfer (dir = 1) writes FIFO head bytes to memory in FIFO order. It stops when the remaining count reaches zero or the FIFO reports empty, whichever happens first, so the byte count is the smaller of `length` and the bytes available.
- R5: `irq_clear` pulses together with `done` only for an inbound transfer that ends with `int_en` high and the FIFO empty. In every other case it stays low.
- R6: A `length` of 0 raises `done` in the cycle after the start edge. It causes no memory request, no transmit beat and no FIFO pop, and `done_count` is 0.
- R7: `done` is high for exactly one cycle, and `done_count` then equals the number of bytes moved.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold, so backpressure loses no byte.
- R9: While `mem_wr_req` is high and `mem_wr_ack` is low, the request, address and data hold. A byte is popped from the FIFO only in a cycle where a write is accepted.
- R10: A start pulse while `busy` is high has no effect on the transfer in progress.
- R11: After reset, `busy`, `done`, `mem_rd_req`, `mem_wr_req`, `tx_valid` and `rx_pop` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle command pulse, accepted only when idle |
| dir | input | 1 | 0 = memory to transmit, 1 = receive FIFO to memory |
| start_addr | input | 64 | First memory byte address |
| length | input | 32 | Byte count |
| int_en | input | 1 | Interrupt enable state of the peripheral |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | 32 | Bytes moved, valid with done |
| irq_clear | output | 1 | Request to drop the receive interrupt, valid with done |
| mem_rd_req | output | 1 | Memory read request (one outstanding) |
| mem_rd_addr | output | 64 | Read address |
| mem_rd_valid | input | 1 | Read data valid, any latency including same cycle |
| mem_rd_data | input | 8 | Read data |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_addr | output | 64 | Write address |
| mem_wr_data | output | 8 | Write data |
| mem_wr_ack | input | 1 | Write accepted |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit sink ready |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_data | input | 8 | Receive FIFO head byte (show-ahead) |
| rx_pop | output | 1 | Pop the receive FIFO head |

## Verification
Two conditions for ending an inbound transfer can occur on the same clock edge: the last remaining byte is accepted, and that pop leaves the receive FIFO empty. The bench sets this up by loading the FIFO with exactly `length` bytes and a random write-accept pattern. It then expects a count equal to `length` with no extra pop, and `irq_clear` high when interrupts are enabled. Other cases sit on either side of this one: FIFO shorter than the count, FIFO longer than the count, and randomized mixes. All are judged against a queue model of the FIFO contents captured before start.

// File: rtl/con_buf_dma.sv
module con_buf_dma #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int CHUNK  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  length,
  input  logic              int_en,
  output logic              busy,
  output logic              done,
  output logic [LEN_W-1:0]  done_count,
  output logic              irq_clear,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        mem_wr_data,
  input  logic              mem_wr_ack,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              rx_empty,
  input  logic [7:0]        rx_data,
  output logic              rx_pop
);

  localparam int CW = $clog2(CHUNK + 1);
  localparam int IW = (CHUNK > 1) ? $clog2(CHUNK) : 1;

  typedef enum logic [2:0] {S_IDLE, S_FILL, S_DRAIN, S_RX, S_DONE} state_t;

  state_t            state;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q, cnt_q;
  logic              dir_q, pend_q;
  logic [CW-1:0]     fill_q, emit_q, chunk_q;
  logic [7:0]        stage [CHUNK];

  function automatic logic [CW-1:0] clip(input logic [LEN_W-1:0] n);
    return (n > LEN_W'(CHUNK)) ? CW'(CHUNK) : n[CW-1:0];
  endfunction

  logic rd_take, tx_go, wr_go, last_fill, last_emit;
  logic [LEN_W-1:0] rem_after;

  assign busy        = state != S_IDLE;
  assign done        = state == S_DONE;
  assign done_count  = cnt_q;
  assign irq_clear   = done && dir_q && int_en && rx_empty;

  assign mem_rd_req  = (state == S_FILL) && !pend_q;
  assign mem_rd_addr = addr_q;
  assign rd_take     = (state == S_FILL) && mem_rd_valid && (pend_q || mem_rd_req);
  assign last_fill   = (fill_q + CW'(1)) == chunk_q;

  assign tx_valid    = state == S_DRAIN;
  assign tx_data     = stage[emit_q[IW-1:0]];
  assign tx_go       = tx_valid && tx_ready;
  assign last_emit   = (emit_q + CW'(1)) == chunk_q;
  assign rem_after   = rem_q - LEN_W'(chunk_q);

  assign mem_wr_req  = (state == S_RX) && (rem_q != '0) && !rx_empty;
  assign mem_wr_addr = addr_q;
  assign mem_wr_data = rx_data;
  assign wr_go       = mem_wr_req && mem_wr_ack;
  assign rx_pop      = wr_go;

  always_ff @(posedge clk) begin
    if (rd_take) stage[fill_q[IW-1:0]] <= mem_rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      pend_q  <= 1'b0;
      fill_q  <= '0;
      emit_q  <= '0;
      chunk_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          addr_q  <= start_addr;
          rem_q   <= length;
          cnt_q   <= '0;
          dir_q   <= dir;
          pend_q  <= 1'b0;
          fill_q  <= '0;
          emit_q  <= '0;
          chunk_q <= clip(length);
          if (length == '0) state <= S_DONE;
          else if (dir)     state <= S_RX;
          else              state <= S_FILL;
        end
        S_FILL: begin
          if (rd_take) begin
            pend_q <= 1'b0;
            addr_q <= addr_q + ADDR_W'(1);
            fill_q <= fill_q + CW'(1);
            if (last_fill) begin
              emit_q <= '0;
              state  <= S_DRAIN;
            end
          end else if (mem_rd_req) begin
            pend_q <= 1'b1;
          end
        end
        S_DRAIN: if (tx_go) begin
          emit_q <= emit_q + CW'(1);
          if (last_emit) begin
            rem_q   <= rem_after;
            cnt_q   <= cnt_q + LEN_W'(chunk_q);
            fill_q  <= '0;
            chunk_q <= clip(rem_after);
            state   <= (rem_after == '0) ? S_DONE : S_FILL;
          end
        end
        S_RX: begin
          if (wr_go) begin
            addr_q <= addr_q + ADDR_W'(1);
            rem_q  <= rem_q - LEN_W'(1);
            cnt_q  <= cnt_q + LEN_W'(1);
          end else if (!mem_wr_req) begin
            state <= S_DONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && !mem_wr_ack |=> mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data));

  // R9
  pop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> mem_wr_req && mem_wr_ack);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd_req && !mem_wr_req && !tx_valid && !rx_pop);

  // R3
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && tx_valid) && !(mem_rd_req && mem_wr_req));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> mem_wr_addr == $past(mem_wr_addr) + ADDR_W'(1));

endmodule

// File: tb/con_buf_dma_bench.sv
module con_buf_dma_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 0, dir = 0, int_en = 0;
  logic [63:0] start_addr = '0;
  logic [31:0] length = '0;
  logic        busy, done, irq_clear, mem_rd_req, mem_wr_req, tx_valid, rx_pop;
  logic [31:0] done_count;
  logic [63:0] mem_rd_addr, mem_wr_addr;
  logic [7:0]  mem_wr_data, tx_data;
  logic        mem_rd_valid = 0, mem_wr_ack = 0, tx_ready = 0, rx_empty = 1;
  logic [7:0]  mem_rd_data = '0, rx_data = '0;

  con_buf_dma u_con_buf_dma (.*);

  int checks = 0, fails = 0;
  logic [7:0]  rxq[$], txg[$], wrd[$];
  logic [63:0] wra[$];
  int rd_taken = 0, tx_taken = 0, max_occ = 0, traffic = 0, done_pulses = 0;
  int ready_pct = 75, ack_pct = 70;
  bit pop_pend = 0, rd_active = 0;
  int rd_delay = 0;
  logic [63:0] rd_addr_l;

  function automatic logic [7:0] mem_byte(input logic [63:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Sink/source models, all updates at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (pop_pend) begin void'(rxq.pop_front()); pop_pend = 0; end
      rx_empty = (rxq.size() == 0);
      rx_data  = rx_empty ? 8'h00 : rxq[0];
      mem_rd_valid = 0;
      if (rd_active) begin
        if (rd_delay == 0) begin
          mem_rd_valid = 1; mem_rd_data = mem_byte(rd_addr_l); rd_active = 0; rd_taken++;
        end else rd_delay--;
      end
      tx_ready   = ($urandom % 100) < ready_pct;
      mem_wr_ack = ($urandom % 100) < ack_pct;
      #1;
      if (mem_rd_req) begin
        int d;
        traffic++;
        d = $urandom % 4;
        rd_addr_l = mem_rd_addr;
        if (d == 0) begin
          mem_rd_valid = 1; mem_rd_data = mem_byte(mem_rd_addr); rd_taken++;
        end else begin
          rd_active = 1; rd_delay = d - 1;
        end
      end
      #1;
      if (tx_valid && tx_ready) begin txg.push_back(tx_data); tx_taken++; traffic++; end
      if (mem_wr_req && mem_wr_ack) begin
        wra.push_back(mem_wr_addr); wrd.push_back(mem_wr_data); pop_pend = 1; traffic++;
      end
      if (rx_pop) traffic++;
      if (rd_taken - tx_taken > max_occ) max_occ = rd_taken - tx_taken;
      if (done) done_pulses++;
    end
  end

  task automatic fill_rx(input int n);
    for (int i = 0; i < n; i++) rxq.push_back(8'($urandom));
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input logic d, input logic [63:0] a, input logic [31:0] n,
                     input bit poke_busy);
    logic [7:0] exp_rx[$];
    int avail, expn, t;
    logic [31:0] dc;
    logic ic;
    exp_rx = rxq;
    avail = rxq.size();
    txg.delete(); wrd.delete(); wra.delete();
    rd_taken = 0; tx_taken = 0; max_occ = 0; traffic = 0; done_pulses = 0;
    @(negedge clk);
    #3;
    start = 1; dir = d; start_addr = a; length = n;
    @(negedge clk);
    #3;
    start = 0;
    if (n == 0) chk("R6 done next cycle", {63'd0, done}, 64'd1);
    t = 0;
    while (!done && t < 20000) begin
      if (poke_busy && t == 5) begin
        start = 1; dir = ~d; start_addr = a + 64'h40; length = 3;
      end else start = 0;
      @(negedge clk); #3; t++;
    end
    start = 0;
    dc = done_count; ic = irq_clear;
    @(negedge clk); #3;
    chk("R7 done single cycle", {63'd0, done}, 64'd0);
    repeat (3) @(negedge clk);
    #3;
    chk("R7 one done pulse", done_pulses, 1);
    if (d == 0) begin
      chk("R1 count", dc, n);
      chk("R1 tx length", txg.size(), n);
      for (int i = 0; i < txg.size() && i < int'(n); i++)
        chk("R1/R2 tx byte", txg[i], mem_byte(a + 64'(i)));
      chk("R3 staging bound", {63'd0, max_occ <= 16}, 64'd1);
      chk("R5 no clear outbound", {63'd0, ic}, 64'd0);
      if (poke_busy) chk("R10 no writes", wrd.size(), 0);
    end else begin
      expn = (avail < int'(n)) ? avail : int'(n);
      chk("R4 count", dc, expn);
      chk("R4 writes", wrd.size(), expn);
      for (int i = 0; i < wrd.size() && i < expn; i++) begin
        chk("R4/R9 data", wrd[i], exp_rx[i]);
        chk("R2 addr", wra[i], a + 64'(i));
      end
      chk("R4 fifo left", rxq.size(), avail - expn);
      chk("R5 clear", {63'd0, ic}, {63'd0, int_en && (avail <= int'(n))});
    end
    if (n == 0) chk("R6 no traffic", traffic, 0);
  endtask

  initial begin
    void'($urandom(32'h2c0f_11a7));
    repeat (3) @(negedge clk);
    #3;
    // R11
    chk("R11 busy", {63'd0, busy}, 0);
    chk("R11 done", {63'd0, done}, 0);
    chk("R11 mem reqs", {62'd0, mem_rd_req, mem_wr_req}, 0);
    chk("R11 tx/pop", {62'd0, tx_valid, rx_pop}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run(0, 64'h100, 5, 0);                       // R1
    run(0, 64'h2000, 40, 0);                     // R3
    chk("R3 bound reached", max_occ, 16);
    run(0, 64'h300, 0, 0);                       // R6
    run(0, 64'hFFFF_FFFF_FFFF_FFFA, 12, 0);      // R2 wrap
    ready_pct = 20;
    run(0, 64'h77, 23, 0);                       // R8 heavy backpressure
    ready_pct = 75;
    run(0, 64'h500, 20, 1);                      // R10
    int_en = 1; fill_rx(10);
    run(1, 64'h1000, 4, 0);                      // R4, R5 not empty
    run(1, 64'h1100, 8, 0);                      // R4 fifo empties early, R5
    rxq.delete(); fill_rx(6);
    run(1, 64'hFFFF_FFFF_FFFF_FFFE, 6, 0);       // same-edge end, R2 wrap
    int_en = 0; fill_rx(3);
    run(1, 64'h1200, 9, 0);                      // R5 disabled
    fill_rx(5);
    run(1, 64'h1300, 0, 0);                      // R6 no pop
    chk("R6 fifo untouched", rxq.size(), 5);
    rxq.delete();
    for (int k = 0; k < 24; k++) begin
      logic dd;
      dd = 1'($urandom);
      int_en = 1'($urandom);
      ready_pct = 30 + ($urandom % 70);
      ack_pct = 30 + ($urandom % 70);
      if (dd) begin rxq.delete(); fill_rx($urandom % 30); end
      run(dd, {$urandom, $urandom}, $urandom % 50, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule